// File: doc/BRIEF.md
# H-Bridge Gate Control with Fault Latch

This block is the digital controller for a full H-bridge built from two half-bridges (legs A and B). Each leg has its own polarity input. A high polarity turns that leg's high-side switch on, and a low polarity turns its low-side switch on. Equal polarities on both legs give braking. Two disable inputs of opposite sense, and a global enable, can force every switch off.

Three fault flags arrive as digital levels from the analog detectors: undervoltage, overtemperature and short-circuit. Undervoltage blanks the bridge only while it is present. Short-circuit and overtemperature are latched. A latched fault holds the bridge off until a deassertion edge on either disable input clears it. After clearing, the outputs rebuild from the polarity inputs present at that time.

Every input passes through a synchroniser before it is used. A dead-time counter, set by an input, keeps each leg from passing straight from one side to the other.

Top module: `hbridge_ctrl`

## Requirements
- R1: During synchronous reset all four gate outputs are low and `fault_n_o` is high.
- R2: With `en_i` low the bridge sleeps: all gates are off, `fault_n_o` is high even while a disable is asserted, and fault flags are not latched. On waking, the outputs follow the polarity inputs.
- R3: With `en_i` high, `dis_hi_i` = 1 or `dis_lo_n_i` = 0 turns all gates off and drives `fault_n_o` low. When both are released, the outputs follow the polarity inputs again.
- R4: With the bridge enabled and fault-free, leg A follows `pol_a_i` and leg B follows `pol_b_i`. Polarity 1 turns on the high side (bit 0 = leg A, bit 1 = leg B of `hs_o`). Polarity 0 turns on the low side (same bit order in `ls_o`).
- R5: Equal polarities brake the motor. Both 1 gives `hs_o` = 2'b11 with `ls_o` = 2'b00. Both 0 gives `ls_o` = 2'b11 with `hs_o` = 2'b00.
- R6: A short-circuit flag seen while enabled latches all gates off and `fault_n_o` low. This holds after the flag drops and whatever the polarity inputs do.
- R7: A latched fault clears on a falling edge of `dis_hi_i` or a rising edge of `dis_lo_n_i`. The gates then follow the present polarity inputs and `fault_n_o` returns high.
- R8: Overtemperature latches like R6. A clear edge that arrives while the temperature flag is still high leaves the latch set. A clear edge after the flag has dropped restores the outputs.
- R9: Undervoltage turns all gates off and drives `fault_n_o` low only while it is present. Recovery needs no clear edge.
- R10: No leg ever has both gates on. When a leg changes side with its polarity held steady, exactly `dead_i` + 1 cycles with both of its gates off separate the two on-states.
- R11: If a fault flag and a clear edge are seen in the same cycle, the fault wins and the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Bridge enable; low means sleep |
| pol_a_i | input | 1 | Polarity of leg A |
| pol_b_i | input | 1 | Polarity of leg B |
| dis_hi_i | input | 1 | Disable, active high |
| dis_lo_n_i | input | 1 | Disable, active low |
| uv_i | input | 1 | Undervoltage flag |
| ot_i | input | 1 | Overtemperature flag (already hysteretic) |
| sc_i | input | 1 | Short-circuit flag |
| dead_i | input | DT_W | Dead-time length in cycles, quasi-static |
| hs_o | output | 2 | High-side gate enables, bit 0 leg A |
| ls_o | output | 2 | Low-side gate enables, bit 0 leg A |
| fault_n_o | output | 1 | Fault status, active low |

## Verification
A clear edge and a new short-circuit flag can fall in the same cycle. When they do, the latch must take the set rather than the clear.

The bench provokes this by releasing `dis_hi_i` and raising `sc_i` on the same clock. Both pass through identical synchroniser chains, so they reach the latch together. The flag is then dropped at once. The bridge is judged to have kept the fault if the gates stay off and `fault_n_o` stays low afterwards. A later clean clear edge must then restore the drive.

The dead-time rule is judged by counting the both-off cycles seen on a leg during a side change, at two dead-time settings.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

    // Synchronised copy of the block's asynchronous inputs
    typedef struct packed {
        logic en;
        logic pol_b;
        logic pol_a;
        logic dis_hi;
        logic dis_lo_n;
        logic uv;
        logic ot;
        logic sc;
    } hb_in_t;

    // Reset value of the synchroniser: asleep, not disabled, no faults
    localparam hb_in_t HB_IN_IDLE = '{en: 1'b0, pol_b: 1'b0, pol_a: 1'b0,
                                      dis_hi: 1'b0, dis_lo_n: 1'b1,
                                      uv: 1'b0, ot: 1'b0, sc: 1'b0};

    // Fault manager state
    typedef struct packed {
        logic dh_prev;
        logic dl_prev;
        logic sc_lat;
        logic ot_lat;
        logic off;
        logic fault_n;
    } hb_flt_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= {STAGES{RST_VAL}};
        else     st_q <= st_d;
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/hb_fault.sv
module hb_fault
    import hbridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic dis_hi_i,
    input  logic dis_lo_n_i,
    input  logic uv_i,
    input  logic ot_i,
    input  logic sc_i,
    output logic off_o,
    output logic fault_n_o
);
    hb_flt_t q, d;
    logic clr;
    logic disabled;

    always_comb begin
        d = q;
        // clear events: release of either disable, seen on synchronised levels
        clr = (q.dh_prev && !dis_hi_i) || (!q.dl_prev && dis_lo_n_i);
        disabled = dis_hi_i || !dis_lo_n_i;
        d.dh_prev = dis_hi_i;
        d.dl_prev = dis_lo_n_i;
        // latches only take flags while awake; a set beats a clear
        if (en_i && sc_i)  d.sc_lat = 1'b1;
        else if (clr)      d.sc_lat = 1'b0;
        if (en_i && ot_i)  d.ot_lat = 1'b1;
        else if (clr)      d.ot_lat = 1'b0;
        if (!en_i) begin
            d.off     = 1'b1;
            d.fault_n = 1'b1;
        end else begin
            d.off     = disabled || uv_i || d.sc_lat || d.ot_lat;
            d.fault_n = !d.off;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{dh_prev: 1'b0, dl_prev: 1'b1, sc_lat: 1'b0,
                        ot_lat: 1'b0, off: 1'b1, fault_n: 1'b1};
        else     q <= d;
    end

    assign off_o     = q.off;
    assign fault_n_o = q.fault_n;

    AST_SC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q.sc_lat && !clr) |=> q.sc_lat); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (en_i && sc_i && clr) |=> (q.sc_lat && !q.fault_n)); // R11
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> q.fault_n); // R2
    AST_UV_OFF: assert property (@(posedge clk) disable iff (rst)
        (en_i && uv_i) |=> (q.off && !q.fault_n)); // R9
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            off_i,
    input  logic            pol_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hs_o,
    output logic            ls_o
);
    typedef struct packed {
        logic            hs;
        logic            ls;
        logic [DT_W-1:0] idle;
    } leg_t;

    localparam logic [DT_W-1:0] IDLE_MAX = '1;

    leg_t q, d;
    logic want_hs, want_ls;
    logic [DT_W-1:0] idle_inc;

    always_comb begin
        d        = q;
        want_hs  = !off_i && pol_i;
        want_ls  = !off_i && !pol_i;
        idle_inc = (q.idle == IDLE_MAX) ? q.idle : q.idle + 1'b1;
        if (want_hs) begin
            if (q.ls) begin
                d.ls = 1'b0; d.idle = '0;
            end else if (!q.hs) begin
                if (q.idle >= dead_i) begin d.hs = 1'b1; d.idle = '0; end
                else                    d.idle = idle_inc;
            end
        end else if (want_ls) begin
            if (q.hs) begin
                d.hs = 1'b0; d.idle = '0;
            end else if (!q.ls) begin
                if (q.idle >= dead_i) begin d.ls = 1'b1; d.idle = '0; end
                else                    d.idle = idle_inc;
            end
        end else begin
            d.hs   = 1'b0;
            d.ls   = 1'b0;
            d.idle = (q.hs || q.ls) ? '0 : idle_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{hs: 1'b0, ls: 1'b0, idle: IDLE_MAX};
        else     q <= d;
    end

    assign hs_o = q.hs;
    assign ls_o = q.ls;

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        !(q.hs && q.ls)); // R10
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        (q.ls && !$past(q.ls)) |-> !$past(q.hs)); // R10
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbridge_pkg::*;
#(
    parameter int DT_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            pol_a_i,
    input  logic            pol_b_i,
    input  logic            dis_hi_i,
    input  logic            dis_lo_n_i,
    input  logic            uv_i,
    input  logic            ot_i,
    input  logic            sc_i,
    input  logic [DT_W-1:0] dead_i,
    output logic [1:0]      hs_o,
    output logic [1:0]      ls_o,
    output logic            fault_n_o
);
    localparam int LEGS  = 2;
    localparam int IN_W  = $bits(hb_in_t);

    hb_in_t          raw, syn;
    logic [IN_W-1:0] syn_v;
    logic            off;
    logic [LEGS-1:0] pol;

    always_comb begin
        raw = '{en: en_i, pol_b: pol_b_i, pol_a: pol_a_i, dis_hi: dis_hi_i,
                dis_lo_n: dis_lo_n_i, uv: uv_i, ot: ot_i, sc: sc_i};
    end

    hb_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(HB_IN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .dout(syn_v)
    );

    assign syn = hb_in_t'(syn_v);
    assign pol = {syn.pol_b, syn.pol_a};

    hb_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .en_i      (syn.en),
        .dis_hi_i  (syn.dis_hi),
        .dis_lo_n_i(syn.dis_lo_n),
        .uv_i      (syn.uv),
        .ot_i      (syn.ot),
        .sc_i      (syn.sc),
        .off_o     (off),
        .fault_n_o (fault_n_o)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hb_leg #(.DT_W(DT_W)) u_leg (
            .clk   (clk),
            .rst   (rst),
            .off_i (off),
            .pol_i (pol[g]),
            .dead_i(dead_i),
            .hs_o  (hs_o[g]),
            .ls_o  (ls_o[g])
        );
    end

    AST_OFF_GATES: assert property (@(posedge clk) disable iff (rst)
        off |=> (hs_o == 2'b00 && ls_o == 2'b00)); // R3
endmodule

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1, pa = 1'b0, pb = 1'b0, dh = 1'b0, dl = 1'b1;
    logic uv = 1'b0, ot = 1'b0, sc = 1'b0;
    logic [3:0] dead = 4'd2;
    logic [1:0] hs, ls;
    logic fn;
    int checks = 0, fails = 0, shoot = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbridge_ctrl u_dut (
        .clk(clk), .rst(rst), .en_i(en), .pol_a_i(pa), .pol_b_i(pb),
        .dis_hi_i(dh), .dis_lo_n_i(dl), .uv_i(uv), .ot_i(ot), .sc_i(sc),
        .dead_i(dead), .hs_o(hs), .ls_o(ls), .fault_n_o(fn)
    );

    always @(negedge clk) if (!rst && ((hs & ls) != 2'b00)) shoot++;

    task automatic settle(int n = 14);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [1:0] ehs, logic [1:0] els, logic efn);
        checks++;
        if (hs !== ehs || ls !== els || fn !== efn) begin
            fails++;
            $display("FAIL %s: hs=%b ls=%b fn=%b expected hs=%b ls=%b fn=%b",
                     tag, hs, ls, fn, ehs, els, efn);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_dis_hi();
        dh = 1'b1; settle(); dh = 1'b0; settle();
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R1 reset", 2'b00, 2'b00, 1'b1);
        rst = 1'b0;
        settle();
    endtask

    task automatic t_drive();
        pa = 1'b1; pb = 1'b0; settle();
        chk("R4 forward", 2'b01, 2'b10, 1'b1);
        pa = 1'b0; pb = 1'b1; settle();
        chk("R4 reverse", 2'b10, 2'b01, 1'b1);
    endtask

    task automatic t_brake();
        pa = 1'b1; pb = 1'b1; settle();
        chk("R5 brake high", 2'b11, 2'b00, 1'b1);
        pa = 1'b0; pb = 1'b0; settle();
        chk("R5 brake low", 2'b00, 2'b11, 1'b1);
    endtask

    task automatic t_disable();
        pa = 1'b1; pb = 1'b0;
        dh = 1'b1; settle();
        chk("R3 dis_hi", 2'b00, 2'b00, 1'b0);
        dh = 1'b0; settle();
        chk("R3 dis_hi release", 2'b01, 2'b10, 1'b1);
        dl = 1'b0; settle();
        chk("R3 dis_lo_n", 2'b00, 2'b00, 1'b0);
        dl = 1'b1; settle();
        chk("R3 dis_lo_n release", 2'b01, 2'b10, 1'b1);
    endtask

    task automatic t_sleep();
        en = 1'b0; dh = 1'b1; settle();
        chk("R2 sleep with disable", 2'b00, 2'b00, 1'b1);
        dh = 1'b0; sc = 1'b1; ot = 1'b1; settle();
        chk("R2 sleep ignores flags", 2'b00, 2'b00, 1'b1);
        sc = 1'b0; ot = 1'b0; settle(4);
        en = 1'b1; settle();
        chk("R2 wake without latch", 2'b01, 2'b10, 1'b1);
    endtask

    task automatic t_short();
        sc = 1'b1; settle(2); sc = 1'b0; settle();
        chk("R6 short latched", 2'b00, 2'b00, 1'b0);
        pa = 1'b0; pb = 1'b1; settle();
        chk("R6 latch ignores polarity", 2'b00, 2'b00, 1'b0);
        pulse_dis_hi();
        chk("R7 clear by dis_hi fall", 2'b10, 2'b01, 1'b1);
        sc = 1'b1; settle(2); sc = 1'b0; settle();
        chk("R6 short latched again", 2'b00, 2'b00, 1'b0);
        pa = 1'b1; pb = 1'b1;
        dl = 1'b0; settle(); dl = 1'b1; settle();
        chk("R7 clear by dis_lo_n rise", 2'b11, 2'b00, 1'b1);
    endtask

    task automatic t_overtemp();
        pa = 1'b1; pb = 1'b0;
        ot = 1'b1; settle();
        chk("R8 overtemp latched", 2'b00, 2'b00, 1'b0);
        pulse_dis_hi();
        chk("R8 clear while hot refused", 2'b00, 2'b00, 1'b0);
        ot = 1'b0; settle();
        chk("R8 cooled but still latched", 2'b00, 2'b00, 1'b0);
        pulse_dis_hi();
        chk("R8 clear after cooling", 2'b01, 2'b10, 1'b1);
    endtask

    task automatic t_uv();
        uv = 1'b1; settle();
        chk("R9 undervoltage off", 2'b00, 2'b00, 1'b0);
        uv = 1'b0; settle();
        chk("R9 auto recovery", 2'b01, 2'b10, 1'b1);
    endtask

    task automatic measure_gap(logic [3:0] dt, string tag);
        int gap = 0;
        dead = dt; pa = 1'b1; pb = 1'b0; settle(20);
        pa = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!hs[0] && !ls[0]) gap++;
            if (ls[0]) break;
        end
        chk_int(tag, gap, int'(dt) + 1);
    endtask

    task automatic t_dead();
        measure_gap(4'd3, "R10 gap dead=3");
        measure_gap(4'd0, "R10 gap dead=0");
        dead = 4'd2; settle();
        chk_int("R10 never both on", shoot, 0);
    endtask

    task automatic t_same_cycle();
        pa = 1'b1; pb = 1'b0;
        dh = 1'b1; settle();
        dh = 1'b0; sc = 1'b1;
        @(negedge clk); sc = 1'b0;
        settle();
        chk("R11 set beats clear", 2'b00, 2'b00, 1'b0);
        pulse_dis_hi();
        chk("R11 later clear restores", 2'b01, 2'b10, 1'b1);
    endtask

    initial begin
        t_reset();
        t_drive();
        t_brake();
        t_disable();
        t_sleep();
        t_short();
        t_overtemp();
        t_uv();
        t_dead();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule